// File: doc/BRIEF.md
# Wrong-Path Miss Usefulness Tracker

This block sits next to a cache's tag array and its miss-status registers and watches the miss, fill, access and eviction events that pass through them. When a miss is issued by a reference that has been marked as wrong-path, the block starts tracking that line. It then sorts the line into one of three classes according to the first correct-path use that follows:

- **full**: the use arrives after the fill has landed.
- **partial**: the use arrives while the fill is still outstanding.
- **unused**: the line leaves the cache with no correct-path use at all.

The block does not decide which path a reference is on. Each event carries that flag, and the flag is only known once the mispredicted branch has resolved. Each class has one saturating counter. A clear pulse, or the synchronous reset, zeroes all three counters together. Per-line tracking survives a clear, so a measurement window can be restarted without losing lines that are still being tracked.

Top module: `wsut_tracker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all three counters read 0.
- R2: A miss event with `miss_wrong`=1 starts tracking its line if the line is untracked. A miss event with `miss_wrong`=0 starts no tracking. Misses and fills on their own never change any counter.
- R3: A correct-path access (`acc_correct`=1) to a tracked line whose fill arrived in an earlier cycle adds 1 to `full_cnt`.
- R4: A correct-path access to a tracked line whose fill has not yet arrived adds 1 to `partial_cnt`. A fill on the same line in the same cycle still counts as not yet arrived.
- R5: An eviction of a tracked line that has had no correct-path access adds 1 to `unused_cnt`.
- R6: Every tracked line is classified once. After its first qualifying access or eviction, the line is untracked, and later accesses or evictions to it change no counter.
- R7: Accesses with `acc_correct`=0 change no counter. A repeated wrong-path miss to a line that is already tracked neither restarts nor reclassifies it. Its in-flight state keeps following the first fill.
- R8: Correct-path accesses and evictions to an untracked line change no counter. This includes a correct-path access that merges with an outstanding correct-path miss.
- R9: If a correct-path access and an eviction hit the same tracked line in one cycle, only the access is counted. If they hit two different tracked lines, both are counted in that cycle.
- R10: Each counter stops at 2^CNT_W-1 and stays there under further increments.
- R11: `clr`=1 zeroes all three counters on the next edge and leaves line tracking unchanged.
- R12: A counted event shows on its counter output on the clock edge that samples the event. That is, the output is registered, with one cycle from event to count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero all counters |
| miss_vld | input | 1 | Miss issued this cycle |
| miss_idx | input | IDX_W | Line index of the miss |
| miss_wrong | input | 1 | Miss comes from a wrong-path reference |
| fill_vld | input | 1 | Fill completed this cycle |
| fill_idx | input | IDX_W | Line index of the fill |
| acc_vld | input | 1 | Access this cycle |
| acc_idx | input | IDX_W | Line index of the access |
| acc_correct | input | 1 | Access comes from a correct-path reference |
| evict_vld | input | 1 | Eviction this cycle |
| evict_idx | input | IDX_W | Line index of the eviction |
| full_cnt | output | CNT_W | Lines used after their fill |
| partial_cnt | output | CNT_W | Lines used while their fill was outstanding |
| unused_cnt | output | CNT_W | Lines evicted without correct-path use |

## Verification
A fill and a correct-path access can land on the same line in the same cycle. The bench provokes this by driving both events for a freshly tracked line on one edge, and expects `partial_cnt` to rise while `full_cnt` holds. A correct-path access and an eviction can also fall in the same cycle. The bench drives them once on a shared line, where only the access may count, and once on two separate tracked lines, where `full_cnt` and `unused_cnt` must both step on the same edge.

// File: rtl/wsut_pkg.sv
package wsut_pkg;
  localparam int NUM_CLS = 3;

  typedef enum logic [1:0] {
    USE_FULL    = 2'd0,
    USE_PARTIAL = 2'd1,
    USE_UNUSED  = 2'd2
  } use_cls_e;
endpackage

// File: rtl/wsut_line_table.sv
module wsut_line_table #(
  parameter int LINES = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_set,
  input  logic [IDX_W-1:0] miss_idx,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  input  logic             ret_a,
  input  logic             ret_b,
  output logic             rd_a_spec,
  output logic             rd_a_infl,
  output logic             rd_b_spec
);
  // Per-line flags: tracked (speculative) and fill outstanding.
  logic [LINES-1:0] spec_q, spec_d;
  logic [LINES-1:0] infl_q, infl_d;

  always_comb begin
    spec_d = spec_q;
    infl_d = infl_q;
    for (int i = 0; i < LINES; i++) begin
      if (fill_vld && fill_idx == IDX_W'(i)) infl_d[i] = 1'b0;
      if ((ret_a && rd_a_idx == IDX_W'(i)) || (ret_b && rd_b_idx == IDX_W'(i))) begin
        spec_d[i] = 1'b0;
        infl_d[i] = 1'b0;
      end
      // Only an untracked line may begin tracking; no restart.
      if (miss_set && miss_idx == IDX_W'(i) && !spec_q[i]) begin
        spec_d[i] = 1'b1;
        infl_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q <= '0;
      infl_q <= '0;
    end else begin
      spec_q <= spec_d;
      infl_q <= infl_d;
    end
  end

  assign rd_a_spec = spec_q[rd_a_idx];
  assign rd_a_infl = infl_q[rd_a_idx];
  assign rd_b_spec = spec_q[rd_b_idx];
endmodule

// File: rtl/wsut_classify.sv
module wsut_classify
  import wsut_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic               acc_vld,
  input  logic               acc_correct,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic               acc_spec,
  input  logic               acc_infl,
  input  logic               ev_vld,
  input  logic [IDX_W-1:0]   ev_idx,
  input  logic               ev_spec,
  output logic               ret_acc,
  output logic               ret_ev,
  output logic [NUM_CLS-1:0] inc
);
  use_cls_e acc_cls;

  always_comb begin
    ret_acc = acc_vld && acc_correct && acc_spec;
    // An access to the same line in the same cycle takes precedence.
    ret_ev  = ev_vld && ev_spec && !(ret_acc && acc_idx == ev_idx);
    acc_cls = acc_infl ? USE_PARTIAL : USE_FULL;
    inc     = '0;
    if (ret_acc) inc[acc_cls] = 1'b1;
    if (ret_ev)  inc[USE_UNUSED] = 1'b1;
  end
endmodule

// File: rtl/wsut_sat_counters.sv
module wsut_sat_counters #(
  parameter int NUM   = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clr)                          cnt[g] <= '0;
      else if (inc[g] && cnt[g] != CNT_MAX)    cnt[g] <= cnt[g] + 1'b1;
    end
  end
endmodule

// File: rtl/wsut_tracker.sv
module wsut_tracker
  import wsut_pkg::*;
#(
  parameter  int LINES = 64,
  parameter  int CNT_W = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             miss_vld,
  input  logic [IDX_W-1:0] miss_idx,
  input  logic             miss_wrong,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             acc_vld,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_correct,
  input  logic             evict_vld,
  input  logic [IDX_W-1:0] evict_idx,
  output logic [CNT_W-1:0] full_cnt,
  output logic [CNT_W-1:0] partial_cnt,
  output logic [CNT_W-1:0] unused_cnt
);
  logic acc_spec, acc_infl, ev_spec, ret_acc, ret_ev;
  logic [NUM_CLS-1:0]            inc;
  logic [NUM_CLS-1:0][CNT_W-1:0] cnt;

  wsut_line_table #(.LINES(LINES), .IDX_W(IDX_W)) table_i (
    .clk(clk), .rst(rst),
    .miss_set(miss_vld && miss_wrong), .miss_idx(miss_idx),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .rd_a_idx(acc_idx), .rd_b_idx(evict_idx),
    .ret_a(ret_acc), .ret_b(ret_ev),
    .rd_a_spec(acc_spec), .rd_a_infl(acc_infl), .rd_b_spec(ev_spec)
  );

  wsut_classify #(.IDX_W(IDX_W)) cls_i (
    .acc_vld(acc_vld), .acc_correct(acc_correct), .acc_idx(acc_idx),
    .acc_spec(acc_spec), .acc_infl(acc_infl),
    .ev_vld(evict_vld), .ev_idx(evict_idx), .ev_spec(ev_spec),
    .ret_acc(ret_acc), .ret_ev(ret_ev), .inc(inc)
  );

  wsut_sat_counters #(.NUM(NUM_CLS), .CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc), .cnt(cnt)
  );

  assign full_cnt    = cnt[USE_FULL];
  assign partial_cnt = cnt[USE_PARTIAL];
  assign unused_cnt  = cnt[USE_UNUSED];
endmodule

// File: rtl/wsut_checker.sv
module wsut_checker #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             acc_vld,
  input logic [IDX_W-1:0] acc_idx,
  input logic             acc_correct,
  input logic             evict_vld,
  input logic [IDX_W-1:0] evict_idx,
  input logic [CNT_W-1:0] full_cnt,
  input logic [CNT_W-1:0] partial_cnt,
  input logic [CNT_W-1:0] unused_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (full_cnt == '0 && partial_cnt == '0 && unused_cnt == '0));

  assert_full_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (full_cnt == CNT_MAX && !clr) |=> full_cnt == CNT_MAX);

  assert_unused_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (unused_cnt == CNT_MAX && !clr) |=> unused_cnt == CNT_MAX);

  assert_wrong_access_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !evict_vld && !(acc_vld && acc_correct))
      |=> ($stable(full_cnt) && $stable(partial_cnt) && $stable(unused_cnt)));

  assert_same_line_access_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && acc_vld && acc_correct && evict_vld && acc_idx == evict_idx)
      |=> $stable(unused_cnt));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((full_cnt == $past(full_cnt) || full_cnt == $past(full_cnt) + CNT_W'(1)) &&
              (partial_cnt == $past(partial_cnt) || partial_cnt == $past(partial_cnt) + CNT_W'(1))));
endmodule

bind wsut_tracker wsut_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .clr(clr),
  .acc_vld(acc_vld), .acc_idx(acc_idx), .acc_correct(acc_correct),
  .evict_vld(evict_vld), .evict_idx(evict_idx),
  .full_cnt(full_cnt), .partial_cnt(partial_cnt), .unused_cnt(unused_cnt)
);

// File: tb/wsut_tracker_tb.sv
module wsut_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int CNT_W = 4;
  localparam int IDX_W = $clog2(LINES);
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst, clr;
  logic miss_vld, miss_wrong, fill_vld, acc_vld, acc_correct, evict_vld;
  logic [IDX_W-1:0] miss_idx, fill_idx, acc_idx, evict_idx;
  logic [CNT_W-1:0] full_cnt, partial_cnt, unused_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsut_tracker #(.LINES(LINES), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .clr(clr),
    .miss_vld(miss_vld), .miss_idx(miss_idx), .miss_wrong(miss_wrong),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .acc_vld(acc_vld), .acc_idx(acc_idx), .acc_correct(acc_correct),
    .evict_vld(evict_vld), .evict_idx(evict_idx),
    .full_cnt(full_cnt), .partial_cnt(partial_cnt), .unused_cnt(unused_cnt)
  );

  typedef struct { int f; int p; int u; string req; } exp_t;
  exp_t exp_q[$];
  int ef = 0, ep = 0, eu = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int sat(input int v);
    return (v < MAXV) ? v + 1 : MAXV;
  endfunction

  // Driver: one event cycle, inputs set away from the rising edge.
  task automatic cyc(input bit mv, input int mi, input bit mw,
                     input bit fv, input int fi,
                     input bit av, input int ai, input bit ac,
                     input bit vv, input int vi, input bit cl);
    @(negedge clk);
    miss_vld = mv; miss_idx = IDX_W'(mi); miss_wrong = mw;
    fill_vld = fv; fill_idx = IDX_W'(fi);
    acc_vld = av; acc_idx = IDX_W'(ai); acc_correct = ac;
    evict_vld = vv; evict_idx = IDX_W'(vi); clr = cl;
    @(posedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_now(input string req);
    exp_t e;
    e.f = ef; e.p = ep; e.u = eu; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compares on the falling edge after each pushed expectation.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (int'(full_cnt) != e.f || int'(partial_cnt) != e.p || int'(unused_cnt) != e.u) begin
        n_fail++;
        $display("FAIL %s: got full=%0d partial=%0d unused=%0d, expected full=%0d partial=%0d unused=%0d",
                 e.req, full_cnt, partial_cnt, unused_cnt, e.f, e.p, e.u);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; clr = 0;
    miss_vld = 0; miss_idx = '0; miss_wrong = 0; fill_vld = 0; fill_idx = '0;
    acc_vld = 0; acc_idx = '0; acc_correct = 0; evict_vld = 0; evict_idx = '0;
    repeat (3) @(posedge clk);
    expect_now("R1 in reset");
    @(negedge clk); rst = 0;
    @(posedge clk); expect_now("R1 after reset");

    // R3: miss, fill, later correct access -> full
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0); expect_now("R2 miss and fill count nothing");
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0); ef++; expect_now("R3 full use, R12 next edge");
    // R4: access before fill -> partial
    cyc(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2, 1, 0, 0, 0); ep++; expect_now("R4 partial use");
    // R4: fill and access in same cycle -> partial
    cyc(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 3, 1, 3, 1, 0, 0, 0); ep++; expect_now("R4 fill same cycle as access");
    // R5: evicted unused
    cyc(1, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 4, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0); eu++; expect_now("R5 evicted unused");
    // R6: already classified line
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0); expect_now("R6 second access no count");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0); expect_now("R6 eviction after use no count");
    cyc(0, 0, 0, 0, 0, 1, 4, 1, 0, 0, 0); expect_now("R6 access after unused eviction");
    // R2/R8: correct-path misses are not tracked
    cyc(1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 5, 1, 0, 0, 0); expect_now("R2 correct miss untracked");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0); expect_now("R8 evict untracked");
    cyc(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 6, 1, 0, 0, 0); expect_now("R8 merge with correct in-flight miss");
    // R7: wrong-path access ignored; repeated wrong miss does not restart
    cyc(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 7, 0, 0, 0, 0); expect_now("R7 wrong-path access ignored");
    cyc(0, 0, 0, 1, 7, 0, 0, 0, 0, 0, 0);
    cyc(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 7, 1, 0, 0, 0); ef++; expect_now("R7 repeat miss keeps full class");
    // R9: access and eviction together
    cyc(1, 8, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 8, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 8, 1, 1, 8, 0); ef++; expect_now("R9 same line access wins");
    cyc(1, 9, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 10, 1, 1, 9, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 9, 1, 1, 10, 0); ef++; eu++; expect_now("R9 two lines both counted");
    // R11: clear zeroes counters, tracking kept
    cyc(1, 11, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); ef = 0; ep = 0; eu = 0; expect_now("R11 clear");
    cyc(0, 0, 0, 0, 0, 1, 11, 1, 0, 0, 0); ep++; expect_now("R11 tracking survives clear");
    // R10: saturation of unused
    for (int k = 0; k < MAXV + 5; k++) begin
      cyc(1, 12, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 12, 0); eu = sat(eu); expect_now("R10 unused saturates");
    end
    idle(); expect_now("R10 held at max");

    idle(); idle();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule